// File: doc/BRIEF.md
# Register Rename Map Unit

This block turns logical register names into physical register tags for an out-of-order core. It holds two complete map tables and a free list of physical tags. The speculative table is read and written at rename. The committed table is written only when an instruction retires. Each cycle the rename port accepts one instruction with two logical sources and an optional logical destination. In the same cycle it returns the physical tags of both sources, a freshly allocated tag for the destination, and the tag that the destination mapped to before this instruction.

The commit port takes at most one retiring instruction per cycle, given as its logical destination and the tag it was allocated. That tag becomes the committed mapping, and the tag it displaces goes back to the free list. A flush copies the committed table over the speculative one and rebuilds the free list from the committed table. All in-flight renames are then forgotten in a single cycle, with no checkpoints and no walk-back.

Top module: `rename_map_unit`

## Requirements
- R1: After reset, logical register i maps to physical tag i in both tables. Tags NUM_LOG through NUM_PHYS-1 are free. `ren_ready` is high, and the first allocation returns tag NUM_LOG.
- R2: `ren_tag_a` and `ren_tag_b` give the speculative mapping of `ren_src_a` and `ren_src_b`, as updated by every earlier accepted rename.
- R3: An accepted rename with `ren_dst_en`=1 returns, on `ren_tag_new`, the lowest-numbered free tag. That tag leaves the free list, and from the next cycle it is the speculative mapping of `ren_dst`.
- R4: A source that names the same logical register as the destination of the same instruction returns the mapping from before this instruction's allocation.
- R5: `ren_out_valid` equals `ren_valid & ren_ready`. On an accepted rename with a destination, `ren_tag_old` is the speculative mapping of `ren_dst` from before the rename.
- R6: `ren_ready` is low when `ren_dst_en`=1 and no tag is free. It stays high for an instruction without a destination. A request that is not accepted changes no state.
- R7: A commit writes `cmt_tag` into the committed entry for `cmt_dst` and frees the tag that entry held before. That tag can be allocated from the next cycle on, but not in the commit cycle.
- R8: While `flush`=1, `ren_ready` is low. From the next cycle, the speculative table equals the committed table, and the free list holds exactly the tags the committed table does not reference.
- R9: A commit presented in the same cycle as a flush is included in the committed table that the flush restores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Restore speculative state from committed state |
| ren_valid | input | 1 | Rename request present |
| ren_ready | output | 1 | Rename request can be accepted this cycle |
| ren_src_a | input | LW | First logical source |
| ren_src_b | input | LW | Second logical source |
| ren_dst_en | input | 1 | Instruction writes a destination |
| ren_dst | input | LW | Logical destination |
| ren_out_valid | output | 1 | Rename accepted this cycle |
| ren_tag_a | output | PW | Physical tag of first source |
| ren_tag_b | output | PW | Physical tag of second source |
| ren_tag_new | output | PW | Newly allocated destination tag |
| ren_tag_old | output | PW | Previous speculative tag of the destination |
| cmt_valid | input | 1 | Retiring instruction present |
| cmt_dst | input | LW | Logical destination being retired |
| cmt_tag | input | PW | Tag allocated to that destination at rename |

## Verification
Allocation and release can fall in the same cycle. So can a commit and a flush. To provoke the first, the bench exhausts the free list and then commits while a rename is held at the port. The reference model must see `ren_ready` stay low in that cycle and must see the freed tag handed out in the next one. To provoke the second, the bench asserts flush together with a commit. It then reads back every logical register and judges the result against a committed table that already contains that commit, together with the free list it implies. Random traffic mixes both overlaps with stalls and reads of the same register that the instruction also writes.

// File: rtl/rename_map_unit.sv
module rename_map_unit #(
  parameter int NUM_LOG  = 8,
  parameter int NUM_PHYS = 16,
  localparam int LW = $clog2(NUM_LOG),
  localparam int PW = $clog2(NUM_PHYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          ren_valid,
  output logic          ren_ready,
  input  logic [LW-1:0] ren_src_a,
  input  logic [LW-1:0] ren_src_b,
  input  logic          ren_dst_en,
  input  logic [LW-1:0] ren_dst,
  output logic          ren_out_valid,
  output logic [PW-1:0] ren_tag_a,
  output logic [PW-1:0] ren_tag_b,
  output logic [PW-1:0] ren_tag_new,
  output logic [PW-1:0] ren_tag_old,
  input  logic          cmt_valid,
  input  logic [LW-1:0] cmt_dst,
  input  logic [PW-1:0] cmt_tag
);

  logic [PW-1:0]       spec_q [NUM_LOG];
  logic [PW-1:0]       com_q  [NUM_LOG];
  logic [PW-1:0]       com_d  [NUM_LOG];
  logic [NUM_PHYS-1:0] free_q, free_d, used;
  logic [PW-1:0]       alloc_tag, freed_tag;
  logic                free_any, alloc;

  assign free_any      = |free_q;
  assign ren_ready     = ~flush & (free_any | ~ren_dst_en);
  assign ren_out_valid = ren_valid & ren_ready;
  assign alloc         = ren_out_valid & ren_dst_en;
  assign ren_tag_a     = spec_q[ren_src_a];
  assign ren_tag_b     = spec_q[ren_src_b];
  assign ren_tag_old   = spec_q[ren_dst];
  assign ren_tag_new   = alloc_tag;
  assign freed_tag     = com_q[cmt_dst];

  always_comb begin
    alloc_tag = '0;
    for (int p = NUM_PHYS - 1; p >= 0; p--)
      if (free_q[p]) alloc_tag = PW'(p);
  end

  always_comb begin
    com_d = com_q;
    if (cmt_valid) com_d[cmt_dst] = cmt_tag;
    used = '0;
    for (int l = 0; l < NUM_LOG; l++) used[com_d[l]] = 1'b1;
  end

  always_comb begin
    free_d = free_q;
    if (alloc)     free_d[alloc_tag] = 1'b0;
    if (cmt_valid) free_d[freed_tag] = 1'b1;
    if (flush)     free_d = ~used;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < NUM_LOG; l++) begin
        spec_q[l] <= PW'(l);
        com_q[l]  <= PW'(l);
      end
      for (int p = 0; p < NUM_PHYS; p++) free_q[p] <= (p >= NUM_LOG);
    end else begin
      com_q  <= com_d;
      free_q <= free_d;
      if (flush)      spec_q <= com_d;
      else if (alloc) spec_q[ren_dst] <= alloc_tag;
    end
  end

endmodule

// File: rtl/rename_map_unit_chk.sv
module rename_map_unit_chk #(
  parameter int NUM_LOG  = 8,
  parameter int NUM_PHYS = 16,
  localparam int PW = $clog2(NUM_PHYS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                flush,
  input logic                ren_valid,
  input logic                ren_ready,
  input logic                ren_dst_en,
  input logic                ren_out_valid,
  input logic [PW-1:0]       ren_tag_new,
  input logic                cmt_valid,
  input logic [NUM_PHYS-1:0] free_q,
  input logic [PW-1:0]       freed_tag
);

  a_r5_accept_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    ren_out_valid |-> (ren_valid && ren_ready));

  a_r8_flush_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !ren_ready);

  a_r6_stall_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (free_q == '0 && ren_dst_en) |-> !ren_ready);

  a_r3_alloc_was_free: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_out_valid && ren_dst_en) |-> free_q[ren_tag_new]);

  a_r3_alloc_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_out_valid && ren_dst_en && !flush) |=> !free_q[$past(ren_tag_new)]);

  a_r7_release_next: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_valid && !flush) |=> free_q[$past(freed_tag)]);

  a_r7_release_was_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid |-> !free_q[freed_tag]);

  a_r8_rebuilt_count: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> ($countones(free_q) == NUM_PHYS - NUM_LOG));

endmodule

bind rename_map_unit rename_map_unit_chk #(.NUM_LOG(NUM_LOG), .NUM_PHYS(NUM_PHYS)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .ren_valid(ren_valid),
  .ren_ready(ren_ready), .ren_dst_en(ren_dst_en), .ren_out_valid(ren_out_valid),
  .ren_tag_new(ren_tag_new), .cmt_valid(cmt_valid), .free_q(free_q),
  .freed_tag(freed_tag)
);

// File: tb/rename_map_unit_tb.sv
module rename_map_unit_tb;
  localparam int NL = 8;
  localparam int NP = 16;
  localparam int LW = $clog2(NL);
  localparam int PW = $clog2(NP);

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic ren_valid = 1'b0, ren_dst_en = 1'b0, cmt_valid = 1'b0;
  logic [LW-1:0] ren_src_a = '0, ren_src_b = '0, ren_dst = '0, cmt_dst = '0;
  logic [PW-1:0] cmt_tag = '0;
  logic ren_ready, ren_out_valid;
  logic [PW-1:0] ren_tag_a, ren_tag_b, ren_tag_new, ren_tag_old;

  always #5 clk = ~clk;

  rename_map_unit #(.NUM_LOG(NL), .NUM_PHYS(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .ren_valid(ren_valid),
    .ren_ready(ren_ready), .ren_src_a(ren_src_a), .ren_src_b(ren_src_b),
    .ren_dst_en(ren_dst_en), .ren_dst(ren_dst), .ren_out_valid(ren_out_valid),
    .ren_tag_a(ren_tag_a), .ren_tag_b(ren_tag_b), .ren_tag_new(ren_tag_new),
    .ren_tag_old(ren_tag_old), .cmt_valid(cmt_valid), .cmt_dst(cmt_dst),
    .cmt_tag(cmt_tag)
  );

  int n_cmp = 0, n_bad = 0;
  int spec [NL];
  int com  [NL];
  bit free [NP];
  int qd[$], qt[$];
  int last_freed = -1;
  bit after_stall = 1'b0;
  string pf_lbl = "";

  task automatic chk(string r, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", r, got, exp);
    end
  endtask

  task automatic step(bit v, bit de, int a, int b, int d, bit wc, bit fl);
    int lowest, f, cd, ct;
    bit rdy, fire, cv;
    string lr, la, lb, ln;
    @(negedge clk);
    cv = wc && (qd.size() > 0);
    cd = cv ? qd[0] : 0;
    ct = cv ? qt[0] : 0;
    ren_valid = v; ren_dst_en = de;
    ren_src_a = LW'(a); ren_src_b = LW'(b); ren_dst = LW'(d);
    cmt_valid = cv; cmt_dst = LW'(cd); cmt_tag = PW'(ct);
    flush = fl;
    #1;
    lowest = -1;
    for (int p = 0; p < NP; p++) if (free[p] && lowest < 0) lowest = p;
    rdy  = !fl && (lowest >= 0 || !de);
    fire = v && rdy;
    lr = fl ? "R8" : ((cv && lowest < 0) ? "R7" : "R6");
    chk(lr, int'(ren_ready), int'(rdy));
    chk("R5", int'(ren_out_valid), int'(fire));
    if (fire) begin
      la = (pf_lbl != "") ? pf_lbl : ((de && a == d) ? "R4" : "R2");
      lb = (pf_lbl != "") ? pf_lbl : ((de && b == d) ? "R4" : "R2");
      chk(la, int'(ren_tag_a), spec[a]);
      chk(lb, int'(ren_tag_b), spec[b]);
      if (de) begin
        ln = (lowest == last_freed) ? "R7" : (after_stall ? "R6" : "R3");
        chk(ln, int'(ren_tag_new), lowest);
        chk("R5", int'(ren_tag_old), spec[d]);
      end
    end
    @(posedge clk);
    after_stall = v && !rdy;
    if (fire && de) begin
      spec[d] = lowest; free[lowest] = 1'b0;
      qd.push_back(d); qt.push_back(lowest);
    end
    last_freed = -1;
    if (cv) begin
      f = com[cd]; com[cd] = ct; free[f] = 1'b1;
      void'(qd.pop_front()); void'(qt.pop_front());
      last_freed = f;
    end
    if ((fire && de) || cv) pf_lbl = "";
    if (fl) begin
      for (int l = 0; l < NL; l++) spec[l] = com[l];
      for (int p = 0; p < NP; p++) free[p] = 1'b1;
      for (int l = 0; l < NL; l++) free[com[l]] = 1'b0;
      qd.delete(); qt.delete();
      pf_lbl = cv ? "R9" : "R8";
      last_freed = -1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got 0 expected 1 (run completed)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int l = 0; l < NL; l++) begin spec[l] = l; com[l] = l; end
    for (int p = 0; p < NP; p++) free[p] = (p >= NL);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R1: identity maps and first free tag, with no request presented
    for (int i = 0; i < NL; i++) begin
      @(negedge clk);
      ren_src_a = LW'(i); ren_src_b = LW'(NL - 1 - i); ren_dst_en = 1'b1;
      #1;
      chk("R1", int'(ren_tag_a), i);
      chk("R1", int'(ren_tag_b), NL - 1 - i);
      chk("R1", int'(ren_tag_new), NL);
      chk("R1", int'(ren_ready), 1);
    end
    step(1, 1, 2, 3, 1, 0, 0);
    step(1, 1, 1, 3, 3, 0, 0);
    step(1, 0, 1, 3, 0, 0, 0);
    for (int k = 0; k < 9; k++) step(1, 1, k % NL, (k + 1) % NL, k % NL, 0, 0);
    step(1, 0, 4, 5, 0, 0, 0);
    step(1, 1, 6, 7, 2, 1, 0);
    step(1, 1, 6, 7, 2, 0, 0);
    step(1, 1, 0, 1, 5, 1, 0);
    step(0, 0, 0, 0, 0, 0, 1);
    for (int i = 0; i < NL; i++) step(1, 0, i, (i + 3) % NL, 0, 0, 0);
    for (int k = 0; k < 5; k++) step(1, 1, k, k + 1, (k * 3) % NL, 0, 0);
    step(0, 0, 0, 0, 0, 1, 1);
    for (int i = 0; i < NL; i++) step(1, 0, i, (i + 5) % NL, 0, 0, 0);
    for (int n = 0; n < 3000; n++)
      step($urandom_range(9) < 8, $urandom_range(3) != 0,
           $urandom_range(NL - 1), $urandom_range(NL - 1), $urandom_range(NL - 1),
           $urandom_range(9) < 4, $urandom_range(49) == 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule